// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM Core

This block is a synthesizable model of a synchronous flow-through burst SRAM that accepts a new read or write command on every enabled clock. Reads and writes can be mixed in any order without idle cycles. Every synchronous input is captured on the rising edge: address, write enable, lane selects, the three chip enables, the burst-continue input and the burst mode. Read data leaves the array combinationally from the registered address, so it appears in the cycle that directly follows the command edge. Write data is presented one cycle after its command.

Write data is parked in a one-entry pending register and committed to the array one enabled clock later. A bypass path lets a read in the very next cycle see that data. The external tri-state bus is modelled as three signals: an input data port, an output data port and a drive-enable. The drive-enable turns itself off during every write-data cycle. An asynchronous active-low output enable gates it without waiting for a clock. A clock-enable input freezes the whole pipeline.

Bursts cover four beats within an aligned group of four addresses. The low two address bits advance either linearly with wrap or in XOR-interleaved order.

Top module: `zt_sram_core`

## Requirements
- R1: An access starts only at an enabled edge with `adv`=0, `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other enable combination with `adv`=0 is a deselect, and `rdata_oe` is 0 in the following cycle.
- R2: While `clk_en`=0, every internal register holds. Outputs keep their values, and write data is taken only at the next enabled edge.
- R3: Any mix of reads and writes, one per enabled clock, completes with no inserted idle cycle, and every read returns the most recent data written to its address.
- R4: Write data on `wdata` is taken at the enabled edge that follows the write command or beat. Only the byte lanes whose `lane_sel` bit (bit i covers data bits 8i+7..8i) was 1 at the command or beat edge are changed.
- R5: A read of the address written by the immediately preceding write beat returns the new data in the cycle after the read command.
- R6: `rdata_oe` is 0 during the data cycle of a write, whatever `oe_n` is.
- R7: `oe_n`=1 forces `rdata_oe` to 0 at once, and `oe_n`=0 re-enables the drive during a read cycle, with no clock edge needed in either case.
- R8: With `burst_ilv`=0 at the load edge, beat k (k=0..3) uses low address bits (base_lo + k) mod 4. The upper address bits stay fixed, and a fifth beat wraps back to k=0.
- R9: With `burst_ilv`=1 at the load edge, beat k uses low address bits base_lo XOR k.
- R10: `adv`=1 continues the current burst with the read or write type latched at load, ignoring `wr_en` and the chip enables. `adv`=1 while idle keeps the block idle.
- R11: Read data for a read command or beat appears on `rdata` in the cycle directly after the edge that registered it, and `rdata_oe` is 1 in that cycle when `oe_n`=0.
- R12: After synchronous reset, no access is active and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; 0 freezes the pipeline |
| adv | input | 1 | 1 continues the current burst, 0 loads a new command |
| wr_en | input | 1 | 1 requests a write on a load cycle |
| lane_sel | input | LANES | Byte-lane write selects, bit i for lane i |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data, driven in the cycle after the write command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DATA_W | Flow-through read data |
| rdata_oe | output | 1 | Drive enable for the read data bus |

## Verification
The bench targets a read that directly follows a write to the same address. A design without the bypass would return stale array contents there. Partial lane writes would show as corrupted neighbouring bytes if lane selects were taken at the wrong edge. Bursts are run from unaligned bases in both orders and past the fourth beat, where a wrong wrap or order function reads a neighbouring word. The bench also freezes the clock enable in the middle of a write-data cycle and changes `wdata`; a design that captured data during the freeze would store the wrong value. It toggles `oe_n` within a cycle, where a registered enable would lag by one clock. Deselects and advances while idle are checked to keep the drive off.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    function automatic logic [BEAT_W-1:0] burst_beat(
        input logic [BEAT_W-1:0] base_lo,
        input logic [BEAT_W-1:0] step,
        input logic              ilv
    );
        return ilv ? (base_lo ^ step) : (base_lo + step);
    endfunction

endpackage

// File: rtl/zt_cmd_stage.sv
module zt_cmd_stage
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              adv,
    input  logic              wr_en,
    input  logic              sel_ok,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_sel,
    output logic              acc_valid,
    output op_e               acc_op,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_lanes
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              valid_q;
    op_e               op_q;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] step_q;
    logic              ilv_q;
    logic [LANES-1:0]  lanes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            op_q    <= OP_READ;
            base_q  <= '0;
            step_q  <= '0;
            ilv_q   <= 1'b0;
            lanes_q <= '0;
        end else if (clk_en) begin
            lanes_q <= lane_sel;
            if (!adv) begin
                valid_q <= sel_ok;
                if (sel_ok) begin
                    base_q <= addr;
                    step_q <= '0;
                    op_q   <= op_e'(wr_en);
                    ilv_q  <= burst_ilv;
                end
            end else if (valid_q) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign acc_valid = valid_q;
    assign acc_op    = op_q;
    assign acc_lanes = lanes_q;
    assign acc_addr  = {base_q[ADDR_W-1 -: HI_W], burst_beat(base_q[BEAT_W-1:0], step_q, ilv_q)};

    assert_freeze_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(valid_q) && $stable(acc_addr) && $stable(op_q) && $stable(lanes_q));

    assert_adv_keeps_type_R10: assert property (@(posedge clk) disable iff (rst)
        (clk_en && adv && valid_q) |=> valid_q && (op_q == $past(op_q)) &&
                                        (step_q == $past(step_q) + 2'd1));

    assert_idle_adv_stays_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (clk_en && adv && !valid_q) |=> !valid_q);

endmodule

// File: rtl/zt_array.sv
module zt_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clk_en,
    input  logic                     wr_beat,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES-1:0]         wr_lanes,
    input  logic [LANE_W*LANES-1:0]  wdata,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANE_W*LANES-1:0]  rd_data
);

    localparam int DATA_W = LANE_W * LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_lanes;
    logic [DATA_W-1:0] pend_data;
    logic              pend_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
        end else if (clk_en) begin
            pend_v <= wr_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (clk_en) begin
            pend_addr  <= wr_addr;
            pend_lanes <= wr_lanes;
            pend_data  <= wdata;
        end
    end

    assign pend_hit = pend_v && (pend_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (clk_en && pend_v && pend_lanes[g]) begin
                mem_q[pend_addr] <= pend_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = (pend_hit && pend_lanes[g])
                                           ? pend_data[g*LANE_W +: LANE_W]
                                           : mem_q[rd_addr];
    end

    assert_wdata_taken_next_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (clk_en && wr_beat) |=> pend_v && (pend_data == $past(wdata)) &&
                                (pend_lanes == $past(wr_lanes)));

    assert_pend_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(pend_v) && $stable(pend_data));

endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clk_en,
    input  logic                     adv,
    input  logic                     wr_en,
    input  logic [LANES-1:0]         lane_sel,
    input  logic                     cs_a_n,
    input  logic                     cs_b,
    input  logic                     cs_c_n,
    input  logic                     burst_ilv,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANE_W*LANES-1:0]  wdata,
    input  logic                     oe_n,
    output logic [LANE_W*LANES-1:0]  rdata,
    output logic                     rdata_oe
);

    localparam int DATA_W = LANE_W * LANES;

    logic              sel_ok;
    logic              acc_valid;
    op_e               acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_lanes;
    logic [DATA_W-1:0] rd_data;
    logic              reading;

    assign sel_ok = !cs_a_n && cs_b && !cs_c_n;

    zt_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) i_cmd (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .adv       (adv),
        .wr_en     (wr_en),
        .sel_ok    (sel_ok),
        .burst_ilv (burst_ilv),
        .addr      (addr),
        .lane_sel  (lane_sel),
        .acc_valid (acc_valid),
        .acc_op    (acc_op),
        .acc_addr  (acc_addr),
        .acc_lanes (acc_lanes)
    );

    zt_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_array (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .wr_beat  (acc_valid && (acc_op == OP_WRITE)),
        .wr_addr  (acc_addr),
        .wr_lanes (acc_lanes),
        .wdata    (wdata),
        .rd_addr  (acc_addr),
        .rd_data  (rd_data)
    );

    assign reading  = acc_valid && (acc_op == OP_READ);
    assign rdata    = reading ? rd_data : '0;
    assign rdata_oe = reading && !oe_n;

    assert_deselect_drive_off_R1: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv && !(!cs_a_n && cs_b && !cs_c_n)) |=> !rdata_oe);

    assert_write_cycle_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !adv && !cs_a_n && cs_b && !cs_c_n && wr_en) |=> !rdata_oe);

    assert_oe_gates_drive_R7: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rdata_oe);

    assert_reset_idle_R12: assert property (@(posedge clk)
        $past(rst) |-> !rdata_oe);

endmodule

// File: tb/test_zt_sram_core.sv
module test_zt_sram_core;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 6;
    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = LANE_W * LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clk_en = 1'b0;
    logic              adv = 1'b0;
    logic              wr_en = 1'b0;
    logic [LANES-1:0]  lane_sel = '0;
    logic              cs_a_n = 1'b1;
    logic              cs_b = 1'b0;
    logic              cs_c_n = 1'b1;
    logic              burst_ilv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              oe_n = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              rdata_oe;

    int checks = 0;
    int fails  = 0;
    string tag = "R12";

    logic [DATA_W-1:0] ref_mem [DEPTH];
    bit                m_valid = 0;
    bit                m_wr = 0;
    logic [ADDR_W-1:0] m_base = '0;
    logic [1:0]        m_step = '0;
    bit                m_ilv = 0;
    logic [LANES-1:0]  m_lanes = '0;

    zt_sram_core #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_zt_sram_core (
        .clk(clk), .rst(rst), .clk_en(clk_en), .adv(adv), .wr_en(wr_en),
        .lane_sel(lane_sel), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .burst_ilv(burst_ilv), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [ADDR_W-1:0] beat_addr(logic [ADDR_W-1:0] base, logic [1:0] k, bit ilv);
        logic [1:0] lo;
        lo = ilv ? (base[1:0] ^ k) : (base[1:0] + k);
        return {base[ADDR_W-1:2], lo};
    endfunction

    function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old, logic [DATA_W-1:0] nw,
                                                logic [LANES-1:0] ln);
        logic [DATA_W-1:0] r;
        r = old;
        for (int i = 0; i < LANES; i++)
            if (ln[i]) r[i*LANE_W +: LANE_W] = nw[i*LANE_W +: LANE_W];
        return r;
    endfunction

    task automatic chk(bit ok, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [ADDR_W-1:0] a;
        if (m_valid && !m_wr) begin
            a = beat_addr(m_base, m_step, m_ilv);
            chk(rdata === ref_mem[a], "read data", rdata, ref_mem[a]);
            chk(rdata_oe === !oe_n, "drive enable on read", DATA_W'(rdata_oe), DATA_W'(!oe_n));
        end else begin
            chk(rdata_oe === 1'b0, "drive enable idle/write", DATA_W'(rdata_oe), '0);
        end
    endtask

    // desel: 0 = all enables active, 1..3 = one enable wrong
    task automatic step(bit en, bit ad, int desel, bit we, logic [ADDR_W-1:0] a,
                        logic [LANES-1:0] ln, bit ilv, bit oe);
        logic [DATA_W-1:0] wd;
        @(negedge clk);
        check_outputs();
        wd = {$urandom, $urandom};
        wdata = wd;
        if (m_valid && m_wr && en) begin
            ref_mem[beat_addr(m_base, m_step, m_ilv)] =
                merge(ref_mem[beat_addr(m_base, m_step, m_ilv)], wd, m_lanes);
        end
        clk_en = en; adv = ad; wr_en = we; addr = a; lane_sel = ln;
        burst_ilv = ilv; oe_n = oe;
        cs_a_n = (desel == 1); cs_b = (desel != 2); cs_c_n = (desel == 3);
        @(posedge clk);
        if (en) begin
            m_lanes = ln;
            if (!ad) begin
                m_valid = (desel == 0);
                if (desel == 0) begin
                    m_base = a; m_step = 0; m_wr = we; m_ilv = ilv;
                end
            end else if (m_valid) begin
                m_step = m_step + 2'd1;
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: idle after reset
        tag = "R12";
        step(1, 0, 1, 0, 0, 4'hF, 0, 0);
        step(1, 1, 0, 0, 0, 4'hF, 0, 0);

        // R3: back-to-back writes fill the whole array
        tag = "R3";
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 1, ADDR_W'(i), 4'hF, 0, 0);
        for (int i = 0; i < 8; i++) step(1, 0, 0, i % 2, ADDR_W'(i * 5), 4'hF, 0, 0);

        // R5: read right after write to same address
        tag = "R5";
        step(1, 0, 0, 1, 20, 4'hF, 0, 0);
        step(1, 0, 0, 0, 20, 4'hF, 0, 0);
        // R11: plain read one cycle after command
        tag = "R11";
        step(1, 0, 0, 0, 21, 4'hF, 0, 0);
        // R4: partial lane write then read
        tag = "R4";
        step(1, 0, 0, 1, 30, 4'b0101, 0, 0);
        step(1, 0, 0, 0, 30, 4'hF, 0, 0);
        step(1, 0, 0, 1, 31, 4'b1000, 0, 0);
        step(1, 0, 0, 0, 40, 4'hF, 0, 0);
        step(1, 0, 0, 0, 31, 4'hF, 0, 0);
        // R6: write data cycle with oe_n low
        tag = "R6";
        step(1, 0, 0, 1, 33, 4'hF, 0, 0);
        step(1, 0, 0, 1, 34, 4'hF, 0, 0);
        // R1: each wrong enable gives a deselect
        tag = "R1";
        for (int d = 1; d <= 3; d++) begin
            step(1, 0, 0, 0, 35, 4'hF, 0, 0);
            step(1, 0, d, 0, 36, 4'hF, 0, 0);
        end
        // R10: advance while idle keeps idle
        tag = "R10";
        step(1, 1, 0, 0, 37, 4'hF, 0, 0);
        step(1, 1, 0, 0, 38, 4'hF, 0, 0);
        // R8: linear read burst from unaligned base, past the wrap
        tag = "R8";
        step(1, 0, 0, 0, 6, 4'hF, 0, 0);
        for (int k = 0; k < 5; k++) step(1, 1, 1, 1, 0, 4'hF, 0, 0);
        // R9: interleaved read burst
        tag = "R9";
        step(1, 0, 0, 0, 13, 4'hF, 1, 0);
        for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 0, 4'hF, 0, 0);
        // R10: write burst continues as write even with wr_en low
        tag = "R10";
        step(1, 0, 0, 1, 45, 4'hF, 1, 0);
        for (int k = 0; k < 3; k++) step(1, 1, 2, 0, 0, 4'b0110, 0, 0);
        for (int k = 44; k < 48; k++) step(1, 0, 0, 0, ADDR_W'(k), 4'hF, 0, 0);
        // R2: freeze during a read and during a write data cycle
        tag = "R2";
        step(1, 0, 0, 0, 50, 4'hF, 0, 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 1, 9, 4'h3, 1, 0);
        step(1, 0, 0, 1, 51, 4'hF, 0, 0);
        for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 2, 4'h0, 0, 0);
        step(1, 0, 0, 0, 51, 4'hF, 0, 0);
        step(1, 0, 0, 0, 50, 4'hF, 0, 0);

        // R7: asynchronous output enable inside one cycle
        tag = "R7";
        step(1, 0, 0, 0, 52, 4'hF, 0, 0);
        @(negedge clk);
        #1;
        chk(rdata_oe === 1'b1, "drive on with oe_n low", DATA_W'(rdata_oe), 1);
        oe_n = 1'b1;
        #1;
        chk(rdata_oe === 1'b0, "drive off after oe_n rise", DATA_W'(rdata_oe), 0);
        oe_n = 1'b0;
        #1;
        chk(rdata_oe === 1'b1, "drive back on after oe_n fall", DATA_W'(rdata_oe), 1);
        clk_en = 1'b0;
        @(posedge clk);

        // R3: constrained random mix
        tag = "R3";
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 10) != 0, ($urandom % 5) < 2,
                 (($urandom % 8) == 0) ? int'(1 + $urandom % 3) : 0,
                 $urandom % 2, ADDR_W'($urandom), LANES'($urandom),
                 $urandom % 2, ($urandom % 10) == 0);
        end
        step(1, 0, 1, 0, 0, 4'hF, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule